// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block runs the bus side of a small I/O space of 2048 locations. The core hands it one read or write request at a time over a valid/ready channel. The block stores the 11-bit location and drives it onto a wider external address bus, with the upper bits held at zero. It raises a select strobe together with a read or a write strobe and keeps them high for a stretch of cycles. It then pulses a completion flag. No peripheral ever answers: the length of each access comes only from a programmable count.

The space is split into four equal regions of 512 locations. Address bits 10:9 pick the region. Each region owns a 3-bit wait-state register, so it can add 0 to 7 wait states. Software loads these registers through a one-cycle write port, and all four come out of reset at 7. An access with N wait states holds the strobes for N+1 cycles, and the completion flag is high in the last of those cycles.

Back-pressure rules: `req_ready` is high only while the generator is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While an access runs, `req_ready` stays low, and a request held on the channel waits without effect. The earliest next transfer is the cycle after the completion pulse. The requester may hold or withdraw `req_valid` freely while `req_ready` is low.

Top module: `iows_top`

## Requirements
- R1: After reset, `req_ready` is 1, while `busy`, `io_sel`, `io_rd`, `io_wr` and `done` are 0. All four wait-state registers hold 7, so an access to any region holds its strobes for 8 cycles.
- R2: The wait count of an access comes from the register indexed by `req_addr[10:9]`: 0 for 0x000–0x1FF, 1 for 0x200–0x3FF, 2 for 0x400–0x5FF and 3 for 0x600–0x7FF.
- R3: An access with N wait states keeps `io_sel` high for exactly N+1 consecutive cycles. `done` is high only in the last of them, and `io_sel` is low in the cycle after `done`.
- R4: During an access, `io_addr[10:0]` equals the accepted `req_addr`, `io_addr[13:11]` is 0, and `io_addr` does not change.
- R5: A request with `req_write`=1 raises `io_wr` and not `io_rd`, and drives the accepted `req_wdata` on `io_wdata` for the whole access. A request with `req_write`=0 raises `io_rd` and not `io_wr`.
- R6: While `busy` is 1, `req_ready` is 0. A request held on `req_valid` during an access starts no access and produces no extra `done`.
- R7: A write to a wait-state register during an access does not change the length of that access. It applies to the next access to that region.
- R8: When a register write and a transfer to the same region fall on the same clock edge, the access uses the value held before the write.
- R9: The strobes rise in the cycle after the transfer edge. After a `done` cycle, one idle cycle with `io_sel` low and `req_ready` high follows before the next access can start.
- R10: `io_sel` is high exactly when `io_rd` or `io_wr` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered by the core |
| req_ready | output | 1 | Generator idle and able to take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 11 | I/O location; bits 10:9 pick the region |
| req_wdata | input | 16 | Write data of the request |
| cfg_we | input | 1 | Write strobe for a wait-state register |
| cfg_sel | input | 2 | Index of the wait-state register to write |
| cfg_val | input | 3 | New wait-state count |
| io_addr | output | 14 | External address; upper 3 bits zero |
| io_wdata | output | 16 | External write data, held during the access |
| io_sel | output | 1 | I/O space select strobe, active high |
| io_rd | output | 1 | Read strobe, active high |
| io_wr | output | 1 | Write strobe, active high |
| done | output | 1 | Final cycle of the access |
| busy | output | 1 | Access in progress |

## Verification
A wrong wait count, from a decoding slip on bits 10:9 or a register loaded at the wrong moment, shows up as a strobe run of the wrong length. That error is visible when `done` arrives, no more than eight cycles after the transfer. A down-counter that skips or stalls makes the run too short or too long, so `done` comes early or late, or the strobes never drop. A corrupted latched address, data or direction bit shows on `io_addr`, `io_wdata` or the read/write strobes in the first strobe cycle. A broken idle/active state shows up as `req_ready` high during an access or a second `done` with no request behind it.

// File: rtl/iows_pkg.sv
package iows_pkg;

  // Sequencer state: waiting for a request, or driving an access.
  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACTIVE = 1'b1
  } seq_state_e;

endpackage

// File: rtl/iows_cfg_regs.sv
// Bank of per-region wait-state registers with a single write port.
module iows_cfg_regs #(
  parameter int NREG      = 4,
  parameter int WS_W      = 3,
  parameter int SEL_W     = $clog2(NREG),
  parameter int RESET_VAL = (1 << WS_W) - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [SEL_W-1:0]           sel,
  input  logic [WS_W-1:0]            wval,
  output logic [NREG-1:0][WS_W-1:0]  ws_o
);

  localparam logic [WS_W-1:0] INIT = WS_W'(RESET_VAL);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we && (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ws_o[g] <= INIT;
      end else if (hit) begin
        ws_o[g] <= wval;
      end
    end
  end

endmodule

// File: rtl/iows_region_dec.sv
// Maps a location to its region and selects that region's wait count.
module iows_region_dec #(
  parameter int ADDR_W = 11,
  parameter int NREG   = 4,
  parameter int WS_W   = 3,
  parameter int SEL_W  = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NREG-1:0][WS_W-1:0]  ws_i,
  output logic [WS_W-1:0]            wait_o
);

  logic [SEL_W-1:0] region;

  // The top address bits divide the space into equal regions.
  assign region = addr[ADDR_W-1 -: SEL_W];

  always_comb begin
    wait_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (region == SEL_W'(i)) begin
        wait_o = ws_i[i];
      end
    end
  end

endmodule

// File: rtl/iows_seq.sv
// Access sequencer: latches a request, counts down the wait states,
// drives the strobes and flags the final cycle.
module iows_seq
  import iows_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int EXT_W  = 14,
  parameter int DATA_W = 16,
  parameter int WS_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [WS_W-1:0]    load_wait,
  output logic [EXT_W-1:0]   io_addr,
  output logic [DATA_W-1:0]  io_wdata,
  output logic               io_sel,
  output logic               io_rd,
  output logic               io_wr,
  output logic               done,
  output logic               busy
);

  localparam int PAD_W = EXT_W - ADDR_W;

  seq_state_e         state;
  logic [WS_W-1:0]    remain;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic               write_q;
  logic               active;
  logic               last;
  logic               take;

  assign active = (state == SEQ_ACTIVE);
  assign last   = active && (remain == '0);
  assign take   = req_valid && (state == SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      remain  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      write_q <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (take) begin
            state   <= SEQ_ACTIVE;
            remain  <= load_wait;
            addr_q  <= req_addr;
            data_q  <= req_wdata;
            write_q <= req_write;
          end
        end
        SEQ_ACTIVE: begin
          if (remain == '0) begin
            state <= SEQ_IDLE;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign req_ready = (state == SEQ_IDLE);
  assign busy      = active;
  assign done      = last;
  assign io_sel    = active;
  assign io_rd     = active && !write_q;
  assign io_wr     = active && write_q;
  assign io_addr   = {{PAD_W{1'b0}}, addr_q};
  assign io_wdata  = data_q;

endmodule

// File: rtl/iows_top.sv
// Region-based I/O wait-state generator.
module iows_top #(
  parameter int ADDR_W = 11,
  parameter int EXT_W  = 14,
  parameter int DATA_W = 16,
  parameter int NREG   = 4,
  parameter int WS_W   = 3,
  parameter int SEL_W  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [WS_W-1:0]    cfg_val,
  output logic [EXT_W-1:0]   io_addr,
  output logic [DATA_W-1:0]  io_wdata,
  output logic               io_sel,
  output logic               io_rd,
  output logic               io_wr,
  output logic               done,
  output logic               busy
);

  logic [NREG-1:0][WS_W-1:0] ws_tbl;
  logic [WS_W-1:0]           sel_wait;

  iows_cfg_regs #(
    .NREG  (NREG),
    .WS_W  (WS_W),
    .SEL_W (SEL_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wval  (cfg_val),
    .ws_o  (ws_tbl)
  );

  iows_region_dec #(
    .ADDR_W (ADDR_W),
    .NREG   (NREG),
    .WS_W   (WS_W),
    .SEL_W  (SEL_W)
  ) u_dec (
    .addr   (req_addr),
    .ws_i   (ws_tbl),
    .wait_o (sel_wait)
  );

  iows_seq #(
    .ADDR_W (ADDR_W),
    .EXT_W  (EXT_W),
    .DATA_W (DATA_W),
    .WS_W   (WS_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .load_wait (sel_wait),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_sel    (io_sel),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .done      (done),
    .busy      (busy)
  );

endmodule

// File: rtl/iows_chk.sv
// Protocol checker bound to the top module.
module iows_chk #(
  parameter int ADDR_W = 11,
  parameter int EXT_W  = 14,
  parameter int DATA_W = 16,
  parameter int WS_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [EXT_W-1:0]   io_addr,
  input logic [DATA_W-1:0]  io_wdata,
  input logic               io_sel,
  input logic               io_rd,
  input logic               io_wr,
  input logic               done,
  input logic               busy
);

  localparam int unsigned MAX_RUN = 1 << WS_W;

  // Consecutive strobe cycles seen before the current one.
  logic [WS_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (!io_sel) run_len <= '0;
    else              run_len <= run_len + 1'b1;
  end

  AST_MAX_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (32'(run_len) < MAX_RUN)); // R3
  AST_DONE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> io_sel); // R3
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !io_sel); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |-> (io_addr[EXT_W-1:ADDR_W] == '0)); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && $past(io_sel) && !$past(done)) |-> $stable(io_addr)); // R4
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && $past(io_wr) && !$past(done)) |-> $stable(io_wdata)); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr)); // R5
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R6
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> io_sel); // R9
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R9
  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel == (io_rd || io_wr)); // R10

endmodule

bind iows_top iows_chk #(
  .ADDR_W (ADDR_W),
  .EXT_W  (EXT_W),
  .DATA_W (DATA_W),
  .WS_W   (WS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .io_sel    (io_sel),
  .io_rd     (io_rd),
  .io_wr     (io_wr),
  .done      (done),
  .busy      (busy)
);

// File: tb/iows_top_tb.sv
module iows_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_val = '0;
  logic [13:0] io_addr;
  logic [15:0] io_wdata;
  logic        io_sel, io_rd, io_wr, done, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  iows_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_sel(io_sel),
    .io_rd(io_rd), .io_wr(io_wr), .done(done), .busy(busy)
  );

  typedef struct {
    logic [10:0] addr;
    logic        wr;
    logic [15:0] data;
    int          waits;
  } exp_t;

  exp_t q[$];
  int   model_ws[4];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_issued = 0;
  int   n_done   = 0;
  int   mon_len  = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // Driver: offer a request, push the expected access at its transfer edge.
  // Optionally writes a wait-state register on the same edge.
  task automatic start_req(input logic [10:0] a, input logic wr, input logic [15:0] d,
                           input bit with_cfg, input int ci, input int cv);
    exp_t e;
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (with_cfg) begin
      cfg_we  = 1'b1;
      cfg_sel = 2'(ci);
      cfg_val = 3'(cv);
    end
    e.addr  = a;
    e.wr    = wr;
    e.data  = d;
    e.waits = model_ws[int'(a[10:9])];
    q.push_back(e);
    n_issued++;
    @(negedge clk);
    check(io_sel == 1'b1, "R9 strobe rises after transfer", int'(io_sel), 1);
    req_valid = 1'b0;
    if (with_cfg) begin
      cfg_we = 1'b0;
      model_ws[ci] = cv;
    end
  endtask

  task automatic cfg_write(input int ci, input int cv);
    cfg_we  = 1'b1;
    cfg_sel = 2'(ci);
    cfg_val = 3'(cv);
    @(negedge clk);
    cfg_we = 1'b0;
    model_ws[ci] = cv;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic access(input logic [10:0] a, input logic wr, input logic [15:0] d);
    start_req(a, wr, d, 1'b0, 0, 0);
    wait_idle();
  endtask

  // Monitor: measure each strobe run and compare with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (io_sel != (io_rd || io_wr))
        check(1'b0, "R10 select matches rd|wr", int'(io_sel), int'(io_rd || io_wr));
      if (io_sel) begin
        mon_len++;
        if (done) begin
          if (q.size() == 0) begin
            check(1'b0, "R6 done with no accepted request", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            n_done++;
            check(mon_len == e.waits + 1, "R2/R3 strobe length", mon_len, e.waits + 1);
            check(io_addr == {3'b000, e.addr}, "R4 external address", int'(io_addr),
                  int'({3'b000, e.addr}));
            check(io_wr == e.wr && io_rd == !e.wr, "R5 direction strobes",
                  int'({io_rd, io_wr}), int'({!e.wr, e.wr}));
            if (e.wr)
              check(io_wdata == e.data, "R5 write data", int'(io_wdata), int'(e.data));
          end
          mon_len = 0;
        end
      end else begin
        if (done) check(1'b0, "R3 done outside access", 1, 0);
        mon_len = 0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) model_ws[i] = 7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle state after reset
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check({io_sel, io_rd, io_wr, done} == 4'b0, "R1 strobes after reset",
          int'({io_sel, io_rd, io_wr, done}), 0);

    // R1/R2: default 7 wait states in every region
    access(11'h000, 1'b0, 16'h0000);
    access(11'h3FF, 1'b1, 16'hA5A5);
    access(11'h400, 1'b0, 16'h0000);
    access(11'h7FF, 1'b1, 16'h5A5A);

    // R2/R3/R5: distinct counts per region, boundary locations
    cfg_write(0, 0);
    cfg_write(1, 3);
    cfg_write(2, 5);
    cfg_write(3, 1);
    access(11'h1FF, 1'b1, 16'h1234);
    access(11'h200, 1'b0, 16'h0000);
    access(11'h5FF, 1'b0, 16'h0000);
    access(11'h600, 1'b1, 16'hBEEF);
    access(11'h000, 1'b0, 16'h0000);

    // R7: register write in the middle of an access
    start_req(11'h2A0, 1'b0, 16'h0000, 1'b0, 0, 0);
    cfg_write(1, 6);
    wait_idle();
    access(11'h300, 1'b1, 16'hC0DE);

    // R8: register write on the transfer edge of the same region
    start_req(11'h480, 1'b1, 16'h7777, 1'b1, 2, 2);
    wait_idle();
    access(11'h481, 1'b0, 16'h0000);

    // R6: request held while busy is neither taken nor counted
    start_req(11'h500, 1'b0, 16'h0000, 1'b0, 0, 0);
    req_valid = 1'b1;
    req_addr  = 11'h010;
    req_write = 1'b1;
    while (!done) begin
      check(req_ready == 1'b0, "R6 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(io_sel == 1'b0, "R6 held request started no access", int'(io_sel), 0);

    // R9: idle gap between back-to-back requests
    start_req(11'h020, 1'b1, 16'h0F0F, 1'b0, 0, 0);
    @(negedge clk);
    check(io_sel == 1'b0 && req_ready == 1'b1, "R9 idle cycle after done",
          int'({io_sel, req_ready}), 1);
    start_req(11'h620, 1'b0, 16'h0000, 1'b0, 0, 0);
    wait_idle();
    repeat (3) @(negedge clk);

    check(q.size() == 0, "R6 all expected accesses seen", q.size(), 0);
    check(n_done == n_issued, "R6 one done per request", n_done, n_issued);
    finish_run();
  end

endmodule